// File: doc/BRIEF.md
# Bayer Sensor Stream Receiver

This block takes the parallel output of an image sensor (a pixel word with a frame-valid and a line-valid qualifier) and turns it into a tagged pixel stream. The inputs are sampled on the falling edge of the pixel clock. For each accepted pixel the block tracks the row and column within the current frame and adds the absolute array address to a window start offset supplied at its ports. From that address it works out the Bayer color of the pixel and whether the pixel lies in the dark border, the boundary ring or the active image area.

Downstream logic gets a valid strobe, the unchanged pixel value, a color code, a region code, the relative row and column counts, and two markers: one on the first pixel of a frame and one on the last pixel of each line. Horizontal blanking keeps frame-valid high, so line ends are found from line-valid alone. A line-valid pulse outside a frame produces no pixels and raises a sticky protocol error.

Top module: `bayer_stream_rx`

## Requirements
- R1: Inputs are sampled on the falling edge of the pixel clock, and the tagged pixel appears on the outputs two falling edges after the edge that sampled it.
- R2: A pixel is emitted (valid high) only for samples where frame-valid and line-valid are both high, and its value is passed through unchanged.
- R3: The color code comes from the parity of the absolute row and column: even row and even column gives Gr = 0, even row and odd column gives R = 1, odd row and even column gives B = 2, odd row and odd column gives Gb = 3.
- R4: Along the columns, the layout from address 0 upward is dark (10 by default), boundary (6), active image (2592), boundary (10), dark (134), each width a parameter.
- R5: Along the rows, the layout from address 0 upward is dark (50 by default), boundary (4), active image (1944), boundary (4), dark (2), each width a parameter.
- R6: The region code is 0 for dark, 1 for boundary and 2 for image: a pixel is dark if either axis is dark, image only if both axes are image, and boundary otherwise. An absolute address past the end of the array is dark. Code 3 is never produced.
- R7: The column count is 0 on the first pixel of each line and rises by one per pixel. The row count is 0 for the first line after frame-valid rises and rises by one per completed line; horizontal blanking with frame-valid high does not end the frame.
- R8: The start-of-frame marker is high with the first valid pixel of a frame only, whether line-valid rises together with or after frame-valid.
- R9: The end-of-line marker is high with the last valid pixel of each line, the one after which line-valid falls.
- R10: A line-valid sample taken while frame-valid is low produces no pixel and sets the protocol error flag, which then stays high until reset.
- R11: While reset is asserted all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk_i | input | 1 | Pixel clock; falling edge is active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_data_i | input | DW | Pixel word from the sensor |
| frame_vld_i | input | 1 | Frame qualifier |
| line_vld_i | input | 1 | Line qualifier |
| col_start_i | input | CW | Absolute column of the window's first pixel |
| row_start_i | input | RW | Absolute row of the window's first line |
| pix_vld_o | output | 1 | Tagged pixel valid |
| pix_data_o | output | DW | Pixel value |
| color_o | output | 2 | Bayer color code |
| region_o | output | 2 | Dark / boundary / image code |
| sof_o | output | 1 | First pixel of frame |
| eol_o | output | 1 | Last pixel of line |
| row_o | output | RW | Row count within the frame |
| col_o | output | CW | Column count within the line |
| proto_err_o | output | 1 | Sticky line-valid-outside-frame flag |

## Verification
The bench builds the receiver with a shrunken array: 14 columns split 2/1/6/2/3 and 11 rows split 3/1/4/1/2, so counters are four bits wide. A 6-by-3 window is sent from every possible column and row start offset, which puts every region edge, both parities on each axis and addresses running past the array end under each window corner. Horizontal blanking length and whether line-valid rises with frame-valid vary between frames, and a stray line-valid pulse outside a frame closes the run.

// File: rtl/brx_pkg.sv
package brx_pkg;

  localparam logic [1:0] RGN_DARK  = 2'd0;
  localparam logic [1:0] RGN_BOUND = 2'd1;
  localparam logic [1:0] RGN_IMAGE = 2'd2;

  // Classify one axis address against its edge layout; past the end is dark.
  function automatic logic [1:0] axis_region(input int unsigned addr,
                                             input int unsigned n_dark_lo,
                                             input int unsigned n_bnd_lo,
                                             input int unsigned n_act,
                                             input int unsigned n_bnd_hi);
    int unsigned e_bnd, e_act, e_act_end, e_bnd_end;
    e_bnd     = n_dark_lo;
    e_act     = e_bnd + n_bnd_lo;
    e_act_end = e_act + n_act;
    e_bnd_end = e_act_end + n_bnd_hi;
    if (addr < e_bnd)          return RGN_DARK;
    else if (addr < e_act)     return RGN_BOUND;
    else if (addr < e_act_end) return RGN_IMAGE;
    else if (addr < e_bnd_end) return RGN_BOUND;
    else                       return RGN_DARK;
  endfunction

  // Codes are ordered dark < boundary < image, so the weaker axis wins.
  function automatic logic [1:0] merge_region(input logic [1:0] a,
                                              input logic [1:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [1:0] bayer_color(input logic row_odd,
                                             input logic col_odd);
    return {row_odd, col_odd};
  endfunction

endpackage

// File: rtl/brx_capture.sv
module brx_capture #(
  parameter int unsigned DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] data_i,
  input  logic          fv_i,
  input  logic          lv_i,
  output logic [DW-1:0] data_o,
  output logic          pix_o,
  output logic          fv_rise_o,
  output logic          line_rise_o,
  output logic          line_fall_o,
  output logic          orphan_o
);

  logic fv_q, lv_q, fv_prev_q, gl_prev_q;
  logic gl_w;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o    <= '0;
      fv_q      <= 1'b0;
      lv_q      <= 1'b0;
      fv_prev_q <= 1'b0;
      gl_prev_q <= 1'b0;
    end else begin
      data_o    <= data_i;
      fv_q      <= fv_i;
      lv_q      <= lv_i;
      fv_prev_q <= fv_q;
      gl_prev_q <= gl_w;
    end
  end

  // Line-valid only counts inside a frame.
  assign gl_w        = fv_q & lv_q;
  assign pix_o       = gl_w;
  assign fv_rise_o   = fv_q & ~fv_prev_q;
  assign line_rise_o = gl_w & ~gl_prev_q;
  assign line_fall_o = ~gl_w & gl_prev_q;
  assign orphan_o    = lv_q & ~fv_q;

endmodule

// File: rtl/brx_position.sv
module brx_position #(
  parameter int unsigned RW = 12,
  parameter int unsigned CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pix_i,
  input  logic          fv_rise_i,
  input  logic          line_rise_i,
  input  logic          line_fall_i,
  output logic [RW-1:0] row_o,
  output logic [CW-1:0] col_o,
  output logic          sof_o
);

  logic [RW-1:0] lines_q;
  logic [CW-1:0] col_q;
  logic          first_pend_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lines_q      <= '0;
      col_q        <= '0;
      first_pend_q <= 1'b0;
    end else begin
      if (fv_rise_i)        lines_q <= '0;
      else if (line_fall_i) lines_q <= lines_q + 1'b1;
      if (pix_i) col_q <= col_o + 1'b1;
      if (fv_rise_i)  first_pend_q <= ~pix_i;
      else if (pix_i) first_pend_q <= 1'b0;
    end
  end

  assign row_o = fv_rise_i   ? '0 : lines_q;
  assign col_o = line_rise_i ? '0 : col_q;
  assign sof_o = pix_i & (fv_rise_i | first_pend_q);

endmodule

// File: rtl/brx_axis_class.sv
module brx_axis_class
  import brx_pkg::*;
#(
  parameter int unsigned AW        = 12,
  parameter int unsigned N_DARK_LO = 10,
  parameter int unsigned N_BND_LO  = 6,
  parameter int unsigned N_ACT     = 2592,
  parameter int unsigned N_BND_HI  = 10
) (
  input  logic [AW-1:0] start_i,
  input  logic [AW-1:0] idx_i,
  output logic [1:0]    region_o,
  output logic          odd_o
);

  logic [AW:0] abs_w;

  assign abs_w    = {1'b0, start_i} + {1'b0, idx_i};
  assign region_o = axis_region(32'(abs_w), N_DARK_LO, N_BND_LO, N_ACT, N_BND_HI);
  assign odd_o    = abs_w[0];

endmodule

// File: rtl/bayer_stream_rx.sv
module bayer_stream_rx
  import brx_pkg::*;
#(
  parameter int unsigned DW        = 12,
  parameter int unsigned H_DARK_LO = 10,
  parameter int unsigned H_BND_LO  = 6,
  parameter int unsigned H_ACT     = 2592,
  parameter int unsigned H_BND_HI  = 10,
  parameter int unsigned H_DARK_HI = 134,
  parameter int unsigned V_DARK_LO = 50,
  parameter int unsigned V_BND_LO  = 4,
  parameter int unsigned V_ACT     = 1944,
  parameter int unsigned V_BND_HI  = 4,
  parameter int unsigned V_DARK_HI = 2,
  localparam int unsigned H_TOTAL  = H_DARK_LO + H_BND_LO + H_ACT + H_BND_HI + H_DARK_HI,
  localparam int unsigned V_TOTAL  = V_DARK_LO + V_BND_LO + V_ACT + V_BND_HI + V_DARK_HI,
  localparam int unsigned CW       = $clog2(H_TOTAL),
  localparam int unsigned RW       = $clog2(V_TOTAL)
) (
  input  logic          pix_clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] pix_data_i,
  input  logic          frame_vld_i,
  input  logic          line_vld_i,
  input  logic [CW-1:0] col_start_i,
  input  logic [RW-1:0] row_start_i,
  output logic          pix_vld_o,
  output logic [DW-1:0] pix_data_o,
  output logic [1:0]    color_o,
  output logic [1:0]    region_o,
  output logic          sof_o,
  output logic          eol_o,
  output logic [RW-1:0] row_o,
  output logic [CW-1:0] col_o,
  output logic          proto_err_o
);

  // Named internal events
  logic [DW-1:0] cap_data_w;
  logic          pix_w, fv_rise_w, line_rise_w, line_fall_w, orphan_w;
  logic [RW-1:0] row_now_w;
  logic [CW-1:0] col_now_w;
  logic          sof_now_w;
  logic [1:0]    col_rgn_w, row_rgn_w;
  logic          col_odd_w, row_odd_w;
  logic          line_end_w;

  brx_capture #(.DW(DW)) u_cap (
    .clk_i       (pix_clk_i),
    .rst_ni      (rst_ni),
    .data_i      (pix_data_i),
    .fv_i        (frame_vld_i),
    .lv_i        (line_vld_i),
    .data_o      (cap_data_w),
    .pix_o       (pix_w),
    .fv_rise_o   (fv_rise_w),
    .line_rise_o (line_rise_w),
    .line_fall_o (line_fall_w),
    .orphan_o    (orphan_w)
  );

  brx_position #(.RW(RW), .CW(CW)) u_pos (
    .clk_i       (pix_clk_i),
    .rst_ni      (rst_ni),
    .pix_i       (pix_w),
    .fv_rise_i   (fv_rise_w),
    .line_rise_i (line_rise_w),
    .line_fall_i (line_fall_w),
    .row_o       (row_now_w),
    .col_o       (col_now_w),
    .sof_o       (sof_now_w)
  );

  brx_axis_class #(
    .AW(CW), .N_DARK_LO(H_DARK_LO), .N_BND_LO(H_BND_LO),
    .N_ACT(H_ACT), .N_BND_HI(H_BND_HI)
  ) u_col_cls (
    .start_i  (col_start_i),
    .idx_i    (col_now_w),
    .region_o (col_rgn_w),
    .odd_o    (col_odd_w)
  );

  brx_axis_class #(
    .AW(RW), .N_DARK_LO(V_DARK_LO), .N_BND_LO(V_BND_LO),
    .N_ACT(V_ACT), .N_BND_HI(V_BND_HI)
  ) u_row_cls (
    .start_i  (row_start_i),
    .idx_i    (row_now_w),
    .region_o (row_rgn_w),
    .odd_o    (row_odd_w)
  );

  // Hold stage: a pixel waits one sample to learn whether its line ended.
  logic          hold_v_q, hold_sof_q;
  logic [1:0]    hold_color_q, hold_rgn_q;
  logic [DW-1:0] hold_data_q;
  logic [RW-1:0] hold_row_q;
  logic [CW-1:0] hold_col_q;
  logic          err_q;

  always_ff @(negedge pix_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_v_q     <= 1'b0;
      hold_sof_q   <= 1'b0;
      hold_color_q <= '0;
      hold_rgn_q   <= '0;
      hold_data_q  <= '0;
      hold_row_q   <= '0;
      hold_col_q   <= '0;
    end else begin
      hold_v_q     <= pix_w;
      hold_sof_q   <= sof_now_w;
      hold_color_q <= bayer_color(row_odd_w, col_odd_w);
      hold_rgn_q   <= merge_region(row_rgn_w, col_rgn_w);
      hold_data_q  <= cap_data_w;
      hold_row_q   <= row_now_w;
      hold_col_q   <= col_now_w;
    end
  end

  assign line_end_w = hold_v_q & ~pix_w;

  always_ff @(negedge pix_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_vld_o  <= 1'b0;
      pix_data_o <= '0;
      color_o    <= '0;
      region_o   <= '0;
      sof_o      <= 1'b0;
      eol_o      <= 1'b0;
      row_o      <= '0;
      col_o      <= '0;
      err_q      <= 1'b0;
    end else begin
      pix_vld_o  <= hold_v_q;
      pix_data_o <= hold_data_q;
      color_o    <= hold_color_q;
      region_o   <= hold_rgn_q;
      sof_o      <= hold_v_q & hold_sof_q;
      eol_o      <= line_end_w;
      row_o      <= hold_row_q;
      col_o      <= hold_col_q;
      if (orphan_w) err_q <= 1'b1;
    end
  end

  assign proto_err_o = err_q;

endmodule

// File: rtl/brx_checks.sv
module brx_checks #(
  parameter int unsigned RW = 12,
  parameter int unsigned CW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          vld_i,
  input logic          sof_i,
  input logic          eol_i,
  input logic [1:0]    region_i,
  input logic [RW-1:0] row_i,
  input logic [CW-1:0] col_i,
  input logic          err_i,
  input logic          orphan_i
);

  p_sof_origin_r8: assert property (@(negedge clk_i) disable iff (!rst_ni)
    sof_i |-> (vld_i && row_i == '0 && col_i == '0));

  p_eol_has_pixel_r9: assert property (@(negedge clk_i) disable iff (!rst_ni)
    eol_i |-> vld_i);

  p_col_step_r7: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (vld_i && !eol_i) |=> (vld_i && col_i == CW'($past(col_i) + 1'b1)));

  p_region_legal_r6: assert property (@(negedge clk_i) disable iff (!rst_ni)
    vld_i |-> (region_i != 2'd3));

  p_err_sticky_r10: assert property (@(negedge clk_i) disable iff (!rst_ni)
    err_i |=> err_i);

  p_orphan_flags_r10: assert property (@(negedge clk_i) disable iff (!rst_ni)
    orphan_i |=> err_i);

endmodule

bind bayer_stream_rx brx_checks #(.RW(RW), .CW(CW)) u_chk (
  .clk_i    (pix_clk_i),
  .rst_ni   (rst_ni),
  .vld_i    (pix_vld_o),
  .sof_i    (sof_o),
  .eol_i    (eol_o),
  .region_i (region_o),
  .row_i    (row_o),
  .col_i    (col_o),
  .err_i    (proto_err_o),
  .orphan_i (orphan_w)
);

// File: tb/bayer_stream_rx_tb.sv
`timescale 1ns/1ps
module bayer_stream_rx_tb;

  localparam int HD0 = 2, HB0 = 1, HA = 6, HB1 = 2, HD1 = 3;
  localparam int VD0 = 3, VB0 = 1, VA = 4, VB1 = 1, VD1 = 2;
  localparam int HT = HD0 + HB0 + HA + HB1 + HD1;
  localparam int VT = VD0 + VB0 + VA + VB1 + VD1;
  localparam int CW = $clog2(HT);
  localparam int RW = $clog2(VT);
  localparam int FW = 6, FH = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   din = '0;
  logic          fv = 1'b0, lv = 1'b0;
  logic [CW-1:0] cstart = '0;
  logic [RW-1:0] rstart = '0;
  logic          vld, sof, eol, err;
  logic [11:0]   dout;
  logic [1:0]    color, region;
  logic [RW-1:0] row;
  logic [CW-1:0] col;

  always #2.5 clk = ~clk;

  bayer_stream_rx #(
    .DW(12), .H_DARK_LO(HD0), .H_BND_LO(HB0), .H_ACT(HA), .H_BND_HI(HB1), .H_DARK_HI(HD1),
    .V_DARK_LO(VD0), .V_BND_LO(VB0), .V_ACT(VA), .V_BND_HI(VB1), .V_DARK_HI(VD1)
  ) u_dut (
    .pix_clk_i(clk), .rst_ni(rst_n), .pix_data_i(din), .frame_vld_i(fv), .line_vld_i(lv),
    .col_start_i(cstart), .row_start_i(rstart), .pix_vld_o(vld), .pix_data_o(dout),
    .color_o(color), .region_o(region), .sof_o(sof), .eol_o(eol), .row_o(row),
    .col_o(col), .proto_err_o(err)
  );

  int total = 0, bad = 0, t = 0;
  int cs_cur = 0, rs_cur = 0;
  bit e_v[8], e_sof[8], e_eol[8];
  int e_d[8], e_c[8], e_r[8], e_row[8], e_col[8];

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d (cycle %0d)", tag, what, act, exp, t);
    end
  endtask

  // Axis layouts written as ranges (R4, R5)
  function automatic int col_kind(input int c);
    if (c >= HD0 + HB0 && c < HD0 + HB0 + HA) return 2;
    if ((c >= HD0 && c < HD0 + HB0) || (c >= HD0 + HB0 + HA && c < HT - HD1)) return 1;
    return 0;
  endfunction

  function automatic int row_kind(input int r);
    if (r >= VD0 + VB0 && r < VD0 + VB0 + VA) return 2;
    if ((r >= VD0 && r < VD0 + VB0) || (r >= VD0 + VB0 + VA && r < VT - VD1)) return 1;
    return 0;
  endfunction

  task automatic step(input bit f, input bit l, input int d, input bit ev,
                      input bit esof, input bit eeol, input int er, input int ec,
                      input string vtag);
    int k, s, ar, ac, rk, ck;
    @(posedge clk); #1;
    k = (t + 5) % 8;
    if (t >= 3) begin
      chk(vtag, "valid", int'(vld), int'(e_v[k]));
      if (e_v[k]) begin
        chk("R2", "data", int'(dout), e_d[k]);
        chk("R3", "color", int'(color), e_c[k]);
        chk("R4 R5 R6", "region", int'(region), e_r[k]);
        chk("R8", "sof", int'(sof), int'(e_sof[k]));
        chk("R9", "eol", int'(eol), int'(e_eol[k]));
        chk("R7", "row", int'(row), e_row[k]);
        chk("R7", "col", int'(col), e_col[k]);
      end
    end
    fv = f; lv = l; din = 12'(d);
    s = t % 8;
    ar = rs_cur + er; ac = cs_cur + ec;
    rk = row_kind(ar); ck = col_kind(ac);
    e_v[s] = ev; e_sof[s] = esof; e_eol[s] = eeol; e_d[s] = d & 12'hfff;
    e_row[s] = er; e_col[s] = ec;
    e_c[s] = (ar % 2) * 2 + (ac % 2);
    e_r[s] = (rk == 0 || ck == 0) ? 0 : ((rk == 2 && ck == 2) ? 2 : 1);
    t++;
  endtask

  task automatic frame(input int cs, input int rs, input bit together, input int hb);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 0, 0, "R1 R2");
    cs_cur = cs; rs_cur = rs;
    cstart = CW'(cs); rstart = RW'(rs);
    if (!together) step(1, 0, 0, 0, 0, 0, 0, 0, "R2");
    for (int r = 0; r < FH; r++) begin
      for (int c = 0; c < FW; c++)
        step(1, 1, (t * 53 + r * 7 + c + 5), 1, (r == 0 && c == 0), (c == FW - 1), r, c, "R1 R2");
      for (int h = 0; h < hb; h++) step(1, 0, 12'habc, 0, 0, 0, 0, 0, "R2 R7");
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, "R2");
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) e_v[i] = 0;
    din = 12'hfff; fv = 1'b1; lv = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R11: outputs held low under reset despite active inputs
    chk("R11", "vld", int'(vld), 0);
    chk("R11", "sof", int'(sof), 0);
    chk("R11", "eol", int'(eol), 0);
    chk("R11", "data", int'(dout), 0);
    chk("R11", "err", int'(err), 0);
    chk("R11", "row/col", int'(row) + int'(col), 0);
    fv = 1'b0; lv = 1'b0; din = '0;
    @(posedge clk); #1;
    rst_n = 1'b1;

    // Sweep every window start over the whole shrunken array
    for (int rs = 0; rs < VT; rs++)
      for (int cs = 0; cs < HT; cs++)
        frame(cs, rs, ((rs + cs) % 2) == 1, 1 + (cs % 3));
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, 0, 0, "R2");
    chk("R10", "err before stray line", int'(err), 0);

    // R10: line-valid outside a frame yields no pixel and latches the flag
    for (int i = 0; i < 3; i++) step(0, 1, 12'h5a5, 0, 0, 0, 0, 0, "R10");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, 0, 0, "R10");
    chk("R10", "err after stray line", int'(err), 1);

    // Normal frame afterwards: still decoded, flag still held
    frame(5, 2, 1'b0, 2);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, 0, 0, "R2");
    chk("R10", "err sticky", int'(err), 1);

    summary();
    $finish;
  end

endmodule